// File: doc/BRIEF.md
# Supply Channel Trip and Interlock Controller

This controller supervises one floating low-voltage supply channel. It decides whether the channel's regulator may be enabled, and it reports the channel's logical status as one of four states: off, on, tripped or interlocked. Fault comparators feed it flags for over-voltage, over-temperature and over-current. It also watches a liveness signal from the local controller, a companion high-voltage channel's trip line, a software interlock and an active-low hardwired interlock.

Over-voltage, over-temperature, loss of communication and a companion trip take the channel down on the next clock edge. An over-current flag trips the channel only if it persists for a programmable time. That time is a count of 2 ms ticks, and the ticks come from a clock prescaler. Every trip sets a sticky cause bit and holds the channel off until a RESET command is given. The settings must then be written again before ON is accepted. While tripped, the channel drives its own peer line so that the companion channel also shuts down.

A lost remote-sense wire either turns the channel off or only raises a warning, depending on a mode input. All inputs are assumed to be synchronous to the clock already.

Top module: `pwr_trip_ctrl`

## Requirements
- R1: After reset, status is 00, supply_en is 0, trip_cause is 0, peer_out is 0 and sense_warn is 0.
- R2: Status codes are OFF=00, ON=01, TRIP=10, INTERLOCK=11. In OFF, cmd_on moves the channel to ON on the next edge only if cfg_wr has been pulsed in OFF since reset or since the last trip. Otherwise cmd_on is ignored. supply_en is 1 exactly while status is ON.
- R3: In ON, if oc_flag stays high for oc_delay×TICK_DIV consecutive edges, the channel enters TRIP on the last of those edges and sets trip_cause bit 0. An oc_delay of 0 acts as 1.
- R4: A low oc_flag restarts the over-current delay from zero.
- R5: In ON, ov_flag high trips the channel on the next edge and sets trip_cause bit 1.
- R6: In ON, ot_flag high trips the channel on the next edge and sets trip_cause bit 2.
- R7: In ON, comm_alive low trips the channel on the next edge and sets trip_cause bit 3 (software trip).
- R8: In ON, peer_in high trips the channel on the next edge and sets trip_cause bit 4. peer_out is high exactly while status is TRIP.
- R9: TRIP holds when the fault flags clear, and cmd_on has no effect there. cmd_reset moves TRIP to OFF and clears trip_cause. A following cmd_on without a new cfg_wr is ignored.
- R10: hw_ilk_n low or sw_ilk high moves the channel to INTERLOCK on the next edge from any state. In INTERLOCK, commands are ignored.
- R11: When both interlocks go inactive, INTERLOCK moves to OFF if trip_cause is zero, or to TRIP if it is not. It never moves to ON.
- R12: In ON with sense_lost high, sense_mode 0 turns the channel OFF without a trip cause. sense_mode 1 keeps the channel ON and sets sense_warn one edge later.
- R13: In ON, cmd_off moves the channel to OFF on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_flag | input | 1 | Over-current comparator flag |
| ov_flag | input | 1 | Over-voltage comparator flag |
| ot_flag | input | 1 | Over-temperature comparator flag |
| comm_alive | input | 1 | High while the local controller is communicating |
| peer_in | input | 1 | Trip line from the companion channel |
| hw_ilk_n | input | 1 | Hardwired interlock, active low |
| sw_ilk | input | 1 | Software interlock command |
| sense_lost | input | 1 | Remote-sense wire disconnected |
| sense_mode | input | 1 | 0: turn off on sense loss, 1: warn only |
| cmd_on | input | 1 | ON command pulse |
| cmd_off | input | 1 | OFF command pulse |
| cmd_reset | input | 1 | RESET command pulse |
| cfg_wr | input | 1 | Settings write strobe; also loads oc_delay |
| oc_delay | input | DLY_W | Over-current delay in 2 ms ticks |
| supply_en | output | 1 | Regulator enable |
| status | output | 2 | Logical status code |
| trip_cause | output | 5 | Sticky trip causes {peer, sw, ot, ov, oc} |
| peer_out | output | 1 | Trip drive to the companion channel |
| sense_warn | output | 1 | Sense-loss warning |

## Verification
The over-current path runs with a flag held one edge short of the delay and then for exactly the delay. It also runs with a flag that drops partway through and then returns, so an off-by-one error or a missing restart shows up. Each fault source is raised alone from ON, and the trip_cause value shows whether the right bit was latched. The interlock is applied from ON, OFF and TRIP, which shows whether release returns the channel to OFF or to TRIP. The reset path is run with and without a new settings write to check the re-arming rule.

// File: rtl/pwr_trip_pkg.sv
package pwr_trip_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_ON   = 2'b01,
    ST_TRIP = 2'b10,
    ST_ILK  = 2'b11
  } chan_st_e;

  localparam int CAUSE_W = 5;
  localparam int CA_OC   = 0;
  localparam int CA_OV   = 1;
  localparam int CA_OT   = 2;
  localparam int CA_SW   = 3;
  localparam int CA_PEER = 4;
endpackage

// File: rtl/oc_delay_timer.sv
module oc_delay_timer #(
  parameter int TICK_DIV = 250000,
  parameter int DLY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [DLY_W-1:0] limit,
  output logic             expire
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DLY_W-1:0] tcnt_q, tcnt_d;
  logic [DLY_W-1:0] lim_eff;
  logic             tick;

  assign lim_eff = (limit == '0) ? DLY_W'(1) : limit;
  assign tick    = (pre_q == PRE_W'(TICK_DIV - 1));
  assign expire  = arm && tick && (tcnt_q == lim_eff - DLY_W'(1));

  always_comb begin
    pre_d  = pre_q;
    tcnt_d = tcnt_q;
    if (!arm) begin
      pre_d  = '0;
      tcnt_d = '0;
    end else if (tick) begin
      pre_d  = '0;
      tcnt_d = expire ? '0 : tcnt_q + DLY_W'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tcnt_q <= '0;
    end else begin
      pre_q  <= pre_d;
      tcnt_q <= tcnt_d;
    end
  end

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (pre_q == '0 && tcnt_q == '0));

  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && tcnt_q < lim_eff - DLY_W'(1)) |-> !expire);
endmodule

// File: rtl/fault_latch.sv
module fault_latch
  import pwr_trip_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [CAUSE_W-1:0] events,
  input  logic               clear,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               fault_evt
);
  logic [CAUSE_W-1:0] cause_d;

  assign fault_evt = capture && (|events);

  always_comb begin
    cause_d = cause_q;
    if (clear)
      cause_d = '0;
    else if (capture)
      cause_d = cause_q | events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/status_fsm.sv
module status_fsm
  import pwr_trip_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ilk_active,
  input  logic     fault_evt,
  input  logic     sense_off,
  input  logic     cause_any,
  input  logic     cmd_on,
  input  logic     cmd_off,
  input  logic     cmd_reset,
  input  logic     cfg_wr,
  output chan_st_e st_q,
  output logic     armed_q,
  output logic     clear_cause
);
  chan_st_e st_d;
  logic     armed_d;

  assign clear_cause = !ilk_active && cmd_reset &&
                       (st_q == ST_TRIP || st_q == ST_OFF);

  always_comb begin
    st_d = st_q;
    if (ilk_active) begin
      st_d = ST_ILK;
    end else begin
      case (st_q)
        ST_OFF:  if (cmd_on && armed_q) st_d = ST_ON;
        ST_ON: begin
          if (fault_evt)                 st_d = ST_TRIP;
          else if (sense_off || cmd_off) st_d = ST_OFF;
        end
        ST_TRIP: if (cmd_reset) st_d = ST_OFF;
        default: st_d = cause_any ? ST_TRIP : ST_OFF;
      endcase
    end
  end

  always_comb begin
    armed_d = armed_q;
    if (st_d == ST_TRIP)
      armed_d = 1'b0;
    else if (cfg_wr && st_q == ST_OFF && !ilk_active)
      armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIP && !cmd_reset && !ilk_active) |=> st_q == ST_TRIP);

  p_no_on_from_trip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRIP) |=> st_q != ST_ON);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ILK && !ilk_active && !cause_any) |=> st_q == ST_OFF);
endmodule

// File: rtl/pwr_trip_ctrl.sv
module pwr_trip_ctrl
  import pwr_trip_pkg::*;
#(
  parameter int TICK_DIV = 250000,
  parameter int DLY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oc_flag,
  input  logic             ov_flag,
  input  logic             ot_flag,
  input  logic             comm_alive,
  input  logic             peer_in,
  input  logic             hw_ilk_n,
  input  logic             sw_ilk,
  input  logic             sense_lost,
  input  logic             sense_mode,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             cmd_reset,
  input  logic             cfg_wr,
  input  logic [DLY_W-1:0] oc_delay,
  output logic             supply_en,
  output logic [1:0]       status,
  output logic [4:0]       trip_cause,
  output logic             peer_out,
  output logic             sense_warn
);
  chan_st_e           st;
  logic               armed;
  logic               clear_cause;
  logic               ilk_active;
  logic               capture;
  logic               oc_expire;
  logic               fault_evt;
  logic               sense_off;
  logic [CAUSE_W-1:0] events;
  logic [CAUSE_W-1:0] cause;
  logic [DLY_W-1:0]   dly_q, dly_d;
  logic               warn_d, warn_q;

  assign ilk_active = !hw_ilk_n || sw_ilk;
  assign capture    = (st == ST_ON) && !ilk_active;
  assign sense_off  = sense_lost && !sense_mode;

  always_comb begin
    events          = '0;
    events[CA_OC]   = oc_expire;
    events[CA_OV]   = ov_flag;
    events[CA_OT]   = ot_flag;
    events[CA_SW]   = !comm_alive;
    events[CA_PEER] = peer_in;
  end

  always_comb begin
    dly_d = dly_q;
    if (cfg_wr && st == ST_OFF && !ilk_active) dly_d = oc_delay;
    warn_d = sense_lost && sense_mode && (st == ST_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= DLY_W'(1);
      warn_q <= 1'b0;
    end else begin
      dly_q  <= dly_d;
      warn_q <= warn_d;
    end
  end

  oc_delay_timer #(.TICK_DIV(TICK_DIV), .DLY_W(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (capture && oc_flag),
    .limit  (dly_q),
    .expire (oc_expire)
  );

  fault_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .events    (events),
    .clear     (clear_cause),
    .cause_q   (cause),
    .fault_evt (fault_evt)
  );

  status_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ilk_active  (ilk_active),
    .fault_evt   (fault_evt),
    .sense_off   (sense_off),
    .cause_any   (|cause),
    .cmd_on      (cmd_on),
    .cmd_off     (cmd_off),
    .cmd_reset   (cmd_reset),
    .cfg_wr      (cfg_wr),
    .st_q        (st),
    .armed_q     (armed),
    .clear_cause (clear_cause)
  );

  assign status     = st;
  assign supply_en  = (st == ST_ON);
  assign peer_out   = (st == ST_TRIP);
  assign trip_cause = cause;
  assign sense_warn = warn_q;

  p_ilk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_ilk_n |=> (status == 2'b11 && !supply_en));

  p_ov_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && ov_flag && hw_ilk_n && !sw_ilk)
      |=> (status == 2'b10 && trip_cause[CA_OV]));

  p_peer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01 && peer_in && hw_ilk_n && !sw_ilk) |=> peer_out);

  p_on_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00 && !armed) |=> status != 2'b01);
endmodule

// File: tb/tb_pwr_trip_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_trip_ctrl;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic oc_flag, ov_flag, ot_flag, comm_alive, peer_in, hw_ilk_n, sw_ilk;
  logic sense_lost, sense_mode, cmd_on, cmd_off, cmd_reset, cfg_wr;
  logic [7:0] oc_delay;
  logic supply_en, peer_out, sense_warn;
  logic [1:0] status;
  logic [4:0] trip_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_trip_ctrl #(.TICK_DIV(DIV), .DLY_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .oc_flag(oc_flag), .ov_flag(ov_flag),
    .ot_flag(ot_flag), .comm_alive(comm_alive), .peer_in(peer_in),
    .hw_ilk_n(hw_ilk_n), .sw_ilk(sw_ilk), .sense_lost(sense_lost),
    .sense_mode(sense_mode), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cmd_reset(cmd_reset), .cfg_wr(cfg_wr), .oc_delay(oc_delay),
    .supply_en(supply_en), .status(status), .trip_cause(trip_cause),
    .peer_out(peer_out), .sense_warn(sense_warn)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] n);
    cfg_wr = 1'b1; oc_delay = n; step(1); cfg_wr = 1'b0;
  endtask

  task automatic pulse_on();  cmd_on = 1'b1; step(1); cmd_on = 1'b0; endtask
  task automatic pulse_rst(); cmd_reset = 1'b1; step(1); cmd_reset = 1'b0; endtask

  task automatic go_on(input logic [7:0] n);
    write_cfg(n); pulse_on();
  endtask

  task automatic t_reset_state();
    check("R1 status", status, 2'b00);
    check("R1 supply_en", supply_en, 0);
    check("R1 trip_cause", trip_cause, 0);
    check("R1 peer_out", peer_out, 0);
    check("R1 sense_warn", sense_warn, 0);
  endtask

  task automatic t_arm_and_on();
    pulse_on();
    check("R2 on ignored without cfg", status, 2'b00);
    go_on(8'd3);
    check("R2 status ON", status, 2'b01);
    check("R2 supply_en", supply_en, 1);
  endtask

  task automatic t_cmd_off();
    cmd_off = 1'b1; step(1); cmd_off = 1'b0;
    check("R13 off", status, 2'b00);
    check("R13 supply_en", supply_en, 0);
  endtask

  task automatic t_oc_delay();
    pulse_on();
    check("R3 back on", status, 2'b01);
    oc_flag = 1'b1; step(3*DIV - 1);
    check("R3 still on one edge early", status, 2'b01);
    step(1);
    check("R3 trip at delay", status, 2'b10);
    check("R3 cause bit0", trip_cause, 5'b00001);
    check("R8 peer_out in trip", peer_out, 1);
    oc_flag = 1'b0;
  endtask

  task automatic t_latch_and_reset();
    step(3);
    check("R9 trip holds", status, 2'b10);
    pulse_on();
    check("R9 on ignored in trip", status, 2'b10);
    pulse_rst();
    check("R9 reset to off", status, 2'b00);
    check("R9 cause cleared", trip_cause, 0);
    pulse_on();
    check("R9 on needs new cfg", status, 2'b00);
    go_on(8'd3);
    check("R9 on after cfg", status, 2'b01);
  endtask

  task automatic t_oc_restart();
    oc_flag = 1'b1; step(10);
    oc_flag = 1'b0; step(1);
    oc_flag = 1'b1; step(3*DIV - 1);
    check("R4 restart holds on", status, 2'b01);
    step(1);
    check("R4 trip after full delay", status, 2'b10);
    oc_flag = 1'b0;
    pulse_rst(); go_on(8'd3);
  endtask

  task automatic t_single(input string req, input int which, input logic [4:0] expc);
    case (which)
      1: ov_flag = 1'b1;
      2: ot_flag = 1'b1;
      3: comm_alive = 1'b0;
      default: peer_in = 1'b1;
    endcase
    step(1);
    check({req, " trip"}, status, 2'b10);
    check({req, " cause"}, trip_cause, expc);
    ov_flag = 1'b0; ot_flag = 1'b0; comm_alive = 1'b1; peer_in = 1'b0;
    pulse_rst(); go_on(8'd3);
    check({req, " recovered"}, status, 2'b01);
  endtask

  task automatic t_interlock();
    hw_ilk_n = 1'b0; step(1);
    check("R10 hw ilk", status, 2'b11);
    check("R10 supply_en", supply_en, 0);
    pulse_on();
    check("R10 on ignored", status, 2'b11);
    hw_ilk_n = 1'b1; step(1);
    check("R11 release to off", status, 2'b00);
    step(2);
    check("R11 stays off", status, 2'b00);
    sw_ilk = 1'b1; step(1);
    check("R10 sw ilk", status, 2'b11);
    sw_ilk = 1'b0; step(1);
    check("R11 sw release off", status, 2'b00);
    pulse_on();
    ov_flag = 1'b1; step(1); ov_flag = 1'b0;
    hw_ilk_n = 1'b0; step(1);
    check("R10 ilk from trip", status, 2'b11);
    hw_ilk_n = 1'b1; step(1);
    check("R11 release to trip", status, 2'b10);
    check("R11 cause kept", trip_cause, 5'b00010);
    pulse_rst(); go_on(8'd3);
  endtask

  task automatic t_sense();
    sense_mode = 1'b1; sense_lost = 1'b1; step(1);
    check("R12 warn mode stays on", status, 2'b01);
    check("R12 warn set", sense_warn, 1);
    sense_lost = 1'b0; step(1);
    sense_mode = 1'b0; sense_lost = 1'b1; step(1);
    check("R12 off mode", status, 2'b00);
    check("R12 no cause", trip_cause, 0);
    sense_lost = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    oc_flag = 0; ov_flag = 0; ot_flag = 0; comm_alive = 1; peer_in = 0;
    hw_ilk_n = 1; sw_ilk = 0; sense_lost = 0; sense_mode = 0;
    cmd_on = 0; cmd_off = 0; cmd_reset = 0; cfg_wr = 0; oc_delay = 8'd1;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset_state();
    t_arm_and_on();
    t_cmd_off();
    t_oc_delay();
    t_latch_and_reset();
    t_oc_restart();
    t_single("R5", 1, 5'b00010);
    t_single("R6", 2, 5'b00100);
    t_single("R7", 3, 5'b01000);
    t_single("R8", 4, 5'b10000);
    t_interlock();
    t_sense();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule